// File: doc/BRIEF.md
# Event Counter Unit

A bank of sixteen 48-bit hardware event counters, set up and read through a simple single-cycle register bus. The bus carries 64-bit data. The upper 32 bits are meaningful only for counter slots. The unit watches a 256-bit event vector in which bit `k` pulses high when the event with code `k` occurs.

Software gives each counter an 8-bit event code, enables the counters it wants, and turns on the global enable. Each armed counter then adds one on every clock in which its chosen event bit is high. When a counter rolls over from all-ones to zero, it sets a sticky status bit. Software clears that bit by writing a one to it. Unmasked status bits are combined into one level interrupt.

Typical use:
- Reset.
- Program the select codes.
- Preload counters if needed.
- Set the per-counter enables, then the global enable.
- On an interrupt, read the status register, handle the counters that wrapped, and clear their bits.

Top module: `evt_count_unit`

## Requirements
- R1: After reset:
  - every counter reads 0;
  - every select register reads 0xFFFFFFFF;
  - the global enable (0x1E00) and the counter enables (0x1E04) read 0;
  - the mask (0x0804) reads 0xFFFF;
  - the status (0x0808) reads 0;
  - `irq_o` is low.
- R2: A counter adds exactly one on each clock edge at which all three of these hold: the global enable is set, its own enable is set, and `evt_i[code]` is high, where `code` is its selected event code.
- R3: A counter whose select code is 0xFF never increments, whatever `evt_i` does.
- R4: When bit 0 of the control register at 0x1E00 is 0, no counter changes except by a bus write.
- R5: Bit `i` of the register at 0x1E04 enables counter `i`. With that bit clear, counter `i` holds its value.
- R6: Counter `i` lives in a 64-bit slot at 0x1F00 + 8·i. Bits 63:48 of the slot read as 0, and bus writes to those bits are dropped.
- R7: The event code of counter `i` is held in bits 8·(i mod 4)+7 : 8·(i mod 4) of the 32-bit register at 0x1E80 + 4·(i div 4). That register reads back as written.
- R8: When a counter steps from 0xFFFF_FFFF_FFFF to 0, bit `i` of the status register at 0x0808 becomes set and stays set.
- R9: Writing a 1 to bit `i` of 0x080C clears status bit `i`, and writing a 0 leaves it unchanged. If a clear and a new wrap of the same counter land on the same edge, the bit stays set. The register at 0x080C reads 0.
- R10: `irq_o` is high exactly while some status bit is set whose bit in the mask at 0x0804 is 0. A mask bit of 1 blocks that counter's interrupt.
- R11: A bus write to a counter slot takes priority over an increment on the same edge: the counter takes the written value.
- R12: Read data is returned on `bus_rdata` with `bus_rvalid` high in the cycle after a read request. Reads of unmapped or misaligned addresses return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address of the register |
| bus_wdata | input | 64 | Write data; 32-bit registers use bits 31:0 |
| bus_rdata | output | 64 | Read data, registered |
| bus_rvalid | output | 1 | High for one cycle when `bus_rdata` carries a read result |
| evt_i | input | 256 | Event pulses, bit k for event code k |
| irq_o | output | 1 | Level interrupt from unmasked status bits |

## Verification
The embedded properties check several rules on every cycle:
- counter stepping, holding and wrap-to-zero;
- write priority over an increment;
- the 0xFF code never counting;
- status bits staying sticky until cleared;
- a simultaneous wrap beating its own clear;
- read-valid timing and zero data from unmapped reads.

The bench's scenarios are needed for the rest. These are the bus address map, the packing of select codes, the dropping of the upper slot bits, the mask polarity on `irq_o`, and the per-counter and global gating seen as counts read back over the bus. They are compared every cycle against an independent behavioural model.

// File: rtl/ecu_pkg.sv
// Package: shared address map and register-region type for the event counter unit.
// Assumes a 16-bit byte address and a 64-bit data bus; 32-bit registers use the low half.
package ecu_pkg;

    localparam int DATA_W = 64;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 16;

    localparam logic [ADDR_W-1:0] OFS_MASK  = 16'h0804;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 16'h0808;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 16'h080C;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 16'h1E00;
    localparam logic [ADDR_W-1:0] OFS_CNTEN = 16'h1E04;
    localparam logic [ADDR_W-1:0] OFS_SEL   = 16'h1E80;
    localparam logic [ADDR_W-1:0] OFS_CNT   = 16'h1F00;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CTRL,
        RG_CNTEN,
        RG_SEL,
        RG_CNT,
        RG_MASK,
        RG_STAT,
        RG_CLR
    } reg_rgn_e;

endpackage

// File: rtl/ecu_decode.sv
// Module: address decoder. Maps a byte address to a register region and a slot index.
// Assumes NUM_CNT >= 2, a whole number of select registers, and counter slots 8 bytes apart.
module ecu_decode #(
    parameter int NUM_CNT = 16,
    parameter int CODE_W  = 8
) (
    input  logic [ecu_pkg::ADDR_W-1:0] addr_i,
    output ecu_pkg::reg_rgn_e          rgn_o,
    output logic [$clog2(NUM_CNT)-1:0] idx_o
);
    import ecu_pkg::*;

    localparam int IDX_W    = $clog2(NUM_CNT);
    localparam int PER_REG  = REG_W / CODE_W;
    localparam int NUM_SEL  = NUM_CNT / PER_REG;
    localparam logic [ADDR_W-1:0] CNT_END = OFS_CNT + ADDR_W'(8 * NUM_CNT);
    localparam logic [ADDR_W-1:0] SEL_END = OFS_SEL + ADDR_W'(4 * NUM_SEL);

    logic [ADDR_W-1:0] cnt_off;
    logic [ADDR_W-1:0] sel_off;
    logic              unused_dec;

    assign cnt_off    = addr_i - OFS_CNT;
    assign sel_off    = addr_i - OFS_SEL;
    assign unused_dec = ^{cnt_off, sel_off};

    // Classify the address; anything unlisted or misaligned falls to RG_NONE.
    always_comb begin
        rgn_o = RG_NONE;
        idx_o = '0;
        if (addr_i == OFS_CTRL) begin
            rgn_o = RG_CTRL;
        end else if (addr_i == OFS_CNTEN) begin
            rgn_o = RG_CNTEN;
        end else if (addr_i == OFS_MASK) begin
            rgn_o = RG_MASK;
        end else if (addr_i == OFS_STAT) begin
            rgn_o = RG_STAT;
        end else if (addr_i == OFS_CLR) begin
            rgn_o = RG_CLR;
        end else if (addr_i >= OFS_SEL && addr_i < SEL_END && addr_i[1:0] == 2'b00) begin
            rgn_o = RG_SEL;
            idx_o = sel_off[2 +: IDX_W];
        end else if (addr_i >= OFS_CNT && addr_i < CNT_END && addr_i[2:0] == 3'b000) begin
            rgn_o = RG_CNT;
            idx_o = cnt_off[3 +: IDX_W];
        end
    end

endmodule

// File: rtl/ecu_config.sv
// Module: configuration registers (global enable, per-counter enables, select codes, mask).
// Assumes write strobes are single-cycle and the region and index are already decoded.
module ecu_config #(
    parameter int NUM_CNT = 16,
    parameter int CODE_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_i,
    input  ecu_pkg::reg_rgn_e           rgn_i,
    input  logic [$clog2(NUM_CNT)-1:0]  idx_i,
    input  logic [ecu_pkg::REG_W-1:0]   wdata_i,
    output logic                        gen_en_o,
    output logic [NUM_CNT-1:0]          cnt_en_o,
    output logic [NUM_CNT-1:0]          run_o,
    output logic [NUM_CNT-1:0]          mask_o,
    output logic [NUM_CNT*CODE_W-1:0]   sel_flat_o
);
    import ecu_pkg::*;

    localparam int IDX_W   = $clog2(NUM_CNT);
    localparam int PER_REG = REG_W / CODE_W;

    logic               gen_q;
    logic [NUM_CNT-1:0] en_q;
    logic [NUM_CNT-1:0] mask_q;

    // Global enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                       gen_q <= 1'b0;
        else if (wr_i && rgn_i == RG_CTRL) gen_q <= wdata_i[0];
    end

    // Per-counter enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n)                        en_q <= '0;
        else if (wr_i && rgn_i == RG_CNTEN) en_q <= wdata_i[NUM_CNT-1:0];
    end

    // Interrupt mask, 1 blocks; all blocked out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                       mask_q <= '1;
        else if (wr_i && rgn_i == RG_MASK) mask_q <= wdata_i[NUM_CNT-1:0];
    end

    // One select code per counter, packed PER_REG codes to a register.
    for (genvar c = 0; c < NUM_CNT; c++) begin : g_sel
        logic [CODE_W-1:0] code_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                code_q <= '1;
            else if (wr_i && rgn_i == RG_SEL && idx_i == IDX_W'(c / PER_REG))
                code_q <= wdata_i[(c % PER_REG)*CODE_W +: CODE_W];
        end
        assign sel_flat_o[c*CODE_W +: CODE_W] = code_q;
    end

    assign gen_en_o = gen_q;
    assign cnt_en_o = en_q;
    assign mask_o   = mask_q;
    assign run_o    = en_q & {NUM_CNT{gen_q}};

endmodule

// File: rtl/ecu_counter.sv
// Module: one event counter slice. Counts its selected event, takes bus writes with priority,
// and flags a wrap. Assumes code all-ones means "no event".
module ecu_counter #(
    parameter int CNT_W  = 48,
    parameter int CODE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [(1<<CODE_W)-1:0]  evt_i,
    input  logic                    run_i,
    input  logic [CODE_W-1:0]       code_i,
    input  logic                    wr_i,
    input  logic [CNT_W-1:0]        wdata_i,
    output logic [CNT_W-1:0]        cnt_o,
    output logic                    ovf_o
);
    localparam logic [CODE_W-1:0] CODE_NONE = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             hit;
    logic             at_max;

    assign hit    = run_i && (code_i != CODE_NONE) && evt_i[code_i];
    assign at_max = &cnt_q;

    // Count register: bus write first, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (wr_i) cnt_q <= wdata_i;
        else if (hit)  cnt_q <= cnt_q + CNT_W'(1);
    end

    assign ovf_o = hit && !wr_i && at_max;
    assign cnt_o = cnt_q;

    // R2: a qualifying event below the top value advances the count by one.
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !wr_i && !at_max) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R4/R5: with the counter not running and no write, the value holds.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !wr_i) |=> $stable(cnt_q));

    // R3: the null code never moves the counter.
    p_null_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i == CODE_NONE && !wr_i) |=> $stable(cnt_q));

    // R11: a write lands even when an event arrives on the same edge.
    p_wr_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (cnt_q == $past(wdata_i)));

    // R8: a wrap leaves the counter at zero.
    p_wrap_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> (cnt_q == '0));

endmodule

// File: rtl/ecu_status.sv
// Module: sticky wrap status with write-one-to-clear, and the combined level interrupt.
// Assumes a new wrap outranks a clear of the same bit on the same edge.
module ecu_status #(
    parameter int NUM_CNT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] ovf_i,
    input  logic [NUM_CNT-1:0] clr_i,
    input  logic [NUM_CNT-1:0] mask_i,
    output logic [NUM_CNT-1:0] status_o,
    output logic               irq_o
);
    logic [NUM_CNT-1:0] stat_q;

    // Status bits: clear by write-one, set by wrap, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_i) | ovf_i;
    end

    assign status_o = stat_q;
    assign irq_o    = |(stat_q & ~mask_i);

    // R8: every wrap shows up in the status on the next cycle.
    p_wrap_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(ovf_i)) == $past(ovf_i)));

    // R8: a set bit that is not cleared stays set.
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(stat_q & ~clr_i)) == $past(stat_q & ~clr_i)));

    // R9: a cleared bit with no new wrap reads zero next cycle.
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(clr_i & ~ovf_i)) == '0));

endmodule

// File: rtl/evt_count_unit.sv
// Module: top of the event counter unit. Decodes bus accesses, hosts the counter slices,
// configuration and status, and returns registered read data one cycle after a read.
// Assumes one access per request cycle and NUM_CNT <= 32, CNT_W <= 64.
module evt_count_unit #(
    parameter int NUM_CNT = 16,
    parameter int CNT_W   = 48,
    parameter int CODE_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_wr,
    input  logic [15:0]          bus_addr,
    input  logic [63:0]          bus_wdata,
    output logic [63:0]          bus_rdata,
    output logic                 bus_rvalid,
    input  logic [(1<<CODE_W)-1:0] evt_i,
    output logic                 irq_o
);
    import ecu_pkg::*;

    localparam int IDX_W = $clog2(NUM_CNT);

    reg_rgn_e                  rgn;
    logic [IDX_W-1:0]          idx;
    logic                      wr_stb;
    logic                      gen_en;
    logic [NUM_CNT-1:0]        cnt_en;
    logic [NUM_CNT-1:0]        run;
    logic [NUM_CNT-1:0]        mask;
    logic [NUM_CNT-1:0]        status;
    logic [NUM_CNT-1:0]        ovf;
    logic [NUM_CNT-1:0]        clr;
    logic [NUM_CNT-1:0]        cnt_wr;
    logic [NUM_CNT*CODE_W-1:0] sel_flat;
    logic [NUM_CNT*CNT_W-1:0]  cnt_flat;
    logic [DATA_W-1:0]         rd_mux;
    logic [DATA_W-1:0]         rdata_q;
    logic                      rvalid_q;
    logic                      unused_wdata;

    assign wr_stb       = bus_req && bus_wr;
    assign unused_wdata = ^bus_wdata[DATA_W-1:CNT_W];

    ecu_decode #(.NUM_CNT(NUM_CNT), .CODE_W(CODE_W)) u_decode (
        .addr_i (bus_addr),
        .rgn_o  (rgn),
        .idx_o  (idx)
    );

    ecu_config #(.NUM_CNT(NUM_CNT), .CODE_W(CODE_W)) u_config (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr_stb),
        .rgn_i      (rgn),
        .idx_i      (idx),
        .wdata_i    (bus_wdata[REG_W-1:0]),
        .gen_en_o   (gen_en),
        .cnt_en_o   (cnt_en),
        .run_o      (run),
        .mask_o     (mask),
        .sel_flat_o (sel_flat)
    );

    for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
        assign cnt_wr[c] = wr_stb && rgn == RG_CNT && idx == IDX_W'(c);
        ecu_counter #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_i   (evt_i),
            .run_i   (run[c]),
            .code_i  (sel_flat[c*CODE_W +: CODE_W]),
            .wr_i    (cnt_wr[c]),
            .wdata_i (bus_wdata[CNT_W-1:0]),
            .cnt_o   (cnt_flat[c*CNT_W +: CNT_W]),
            .ovf_o   (ovf[c])
        );
    end

    assign clr = (wr_stb && rgn == RG_CLR) ? bus_wdata[NUM_CNT-1:0] : '0;

    ecu_status #(.NUM_CNT(NUM_CNT)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovf_i    (ovf),
        .clr_i    (clr),
        .mask_i   (mask),
        .status_o (status),
        .irq_o    (irq_o)
    );

    // Read mux: selects the addressed register, zero-filling unused bits.
    always_comb begin
        rd_mux = '0;
        unique case (rgn)
            RG_CTRL:  rd_mux[0]            = gen_en;
            RG_CNTEN: rd_mux[NUM_CNT-1:0]  = cnt_en;
            RG_MASK:  rd_mux[NUM_CNT-1:0]  = mask;
            RG_STAT:  rd_mux[NUM_CNT-1:0]  = status;
            RG_SEL:   rd_mux[REG_W-1:0]    = sel_flat[int'(idx)*REG_W +: REG_W];
            RG_CNT:   rd_mux[CNT_W-1:0]    = cnt_flat[int'(idx)*CNT_W +: CNT_W];
            default:  rd_mux               = '0;
        endcase
    end

    // Read response register: data and one-cycle valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= bus_req && !bus_wr;
            if (bus_req && !bus_wr) rdata_q <= rd_mux;
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;

    // R12: a read request is answered on the next cycle, and only then.
    p_rvalid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (bus_rvalid == $past(bus_req && !bus_wr)));

    // R12: unmapped reads return zero.
    p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_wr && rgn == RG_NONE) |=> (bus_rdata == '0));

    // R6: the upper bits of a counter read are always zero.
    p_slot_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_wr && rgn == RG_CNT) |=> (bus_rdata[DATA_W-1:CNT_W] == '0));

endmodule

// File: tb/evt_count_unit_bench.sv
`timescale 1ns/1ps
// Bench: drives register accesses and events, and compares the unit every clock
// against a behavioural model written from the requirements.
module evt_count_unit_bench;

    localparam int NC = 16;
    localparam longint unsigned CMAX = 64'h0000_FFFF_FFFF_FFFF;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req = 1'b0;
    logic         wr = 1'b0;
    logic [15:0]  addr = '0;
    logic [63:0]  wdata = '0;
    logic [255:0] evt = '0;
    logic [63:0]  rdata;
    logic         rvalid;
    logic         irq;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_tag = "R1 reset";

    // model state
    longint unsigned m_cnt [NC];
    logic [7:0]      m_sel [NC];
    logic            m_gen;
    logic [15:0]     m_en, m_mask, m_stat;
    logic [63:0]     exp_rd;
    logic            exp_rv;
    string           exp_tag;

    always #4 clk = ~clk;

    evt_count_unit u_evt_count_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_req    (req),
        .bus_wr     (wr),
        .bus_addr   (addr),
        .bus_wdata  (wdata),
        .bus_rdata  (rdata),
        .bus_rvalid (rvalid),
        .evt_i      (evt),
        .irq_o      (irq)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] m_read(input logic [15:0] a);
        int k;
        if (a == 16'h1E00) return {63'b0, m_gen};
        if (a == 16'h1E04) return {48'b0, m_en};
        if (a == 16'h0804) return {48'b0, m_mask};
        if (a == 16'h0808) return {48'b0, m_stat};
        if (a >= 16'h1E80 && a < 16'h1E90 && a[1:0] == 2'b00) begin
            k = int'(a - 16'h1E80) / 4;
            return {32'b0, m_sel[4*k+3], m_sel[4*k+2], m_sel[4*k+1], m_sel[4*k]};
        end
        if (a >= 16'h1F00 && a < 16'h1F80 && a[2:0] == 3'b000) begin
            k = int'(a - 16'h1F00) / 8;
            return m_cnt[k];
        end
        return 64'b0;
    endfunction

    // Reference model: updates on the same edges as the unit, from pre-edge state.
    always @(posedge clk) begin
        logic [15:0] ovf;
        logic [15:0] clr;
        int k;
        if (!rst_n) begin
            for (int c = 0; c < NC; c++) begin
                m_cnt[c] = 0;
                m_sel[c] = 8'hFF;
            end
            m_gen = 0; m_en = '0; m_mask = '1; m_stat = '0;
            exp_rv = 0; exp_rd = '0; exp_tag = "R1 reset";
        end else begin
            exp_rv = req && !wr;
            if (exp_rv) begin
                exp_rd  = m_read(addr);
                exp_tag = cur_tag;
            end
            ovf = '0;
            clr = '0;
            for (int c = 0; c < NC; c++) begin
                if (req && wr && addr == 16'h1F00 + 16'(8*c))
                    m_cnt[c] = wdata & CMAX;
                else if (m_gen && m_en[c] && m_sel[c] != 8'hFF && evt[m_sel[c]]) begin
                    if (m_cnt[c] == CMAX) begin
                        m_cnt[c] = 0;
                        ovf[c] = 1'b1;
                    end else begin
                        m_cnt[c] = m_cnt[c] + 1;
                    end
                end
            end
            if (req && wr) begin
                if (addr == 16'h1E00) m_gen = wdata[0];
                if (addr == 16'h1E04) m_en = wdata[15:0];
                if (addr == 16'h0804) m_mask = wdata[15:0];
                if (addr == 16'h080C) clr = wdata[15:0];
                if (addr >= 16'h1E80 && addr < 16'h1E90 && addr[1:0] == 2'b00) begin
                    k = int'(addr - 16'h1E80) / 4;
                    for (int j = 0; j < 4; j++) m_sel[4*k+j] = wdata[8*j +: 8];
                end
            end
            m_stat = (m_stat & ~clr) | ovf;
        end
    end

    // Every-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(irq == |(m_stat & ~m_mask), "R10 irq level", {63'b0, irq}, {63'b0, |(m_stat & ~m_mask)});
            check(rvalid == exp_rv, "R12 read valid", {63'b0, rvalid}, {63'b0, exp_rv});
            if (exp_rv) check(rdata == exp_rd, exp_tag, rdata, exp_rd);
        end
    end

    task automatic bus_write(input logic [15:0] a, input logic [63:0] d);
        req = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a);
        req = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL R12 watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset values of every region, plus irq low
        cur_tag = "R1 reset value";
        bus_read(16'h1E00); bus_read(16'h1E04); bus_read(16'h1E80); bus_read(16'h1E8C);
        bus_read(16'h0804); bus_read(16'h0808); bus_read(16'h1F00); bus_read(16'h1F78);
        check(irq == 1'b0, "R1 irq after reset", {63'b0, irq}, 64'b0);

        // R7: select code packing and read-back
        cur_tag = "R7 select packing";
        bus_write(16'h1E80, 64'h0000_0000_0302_0100);
        bus_write(16'h1E84, 64'h0000_0000_0706_FF05);
        bus_read(16'h1E80); bus_read(16'h1E84);
        check(rdata == 64'h0706_FF05, "R7 second select reg", rdata, 64'h0706_FF05);

        // R2: counting under mixed event patterns
        cur_tag = "R2 counting";
        bus_write(16'h1E04, 64'h00FF);
        bus_write(16'h1E00, 64'h1);
        evt[0] = 1'b1; idle(5);
        evt[1] = 1'b1; evt[2] = 1'b1; idle(2);
        evt[0] = 1'b0; idle(3);
        evt = '0;
        bus_read(16'h1F00); bus_read(16'h1F08); bus_read(16'h1F10); bus_read(16'h1F18);
        check(rdata == 64'd0, "R2 counter3 never saw event 3", rdata, 64'd0);

        // R3: null code never counts
        cur_tag = "R3 null code";
        evt = '1; idle(4); evt = '0;
        bus_read(16'h1F28); bus_read(16'h1F20);

        // R4: global enable clear stops everything
        cur_tag = "R4 global off";
        bus_write(16'h1E00, 64'h0);
        evt = '1; idle(4); evt = '0;
        bus_read(16'h1F00); bus_read(16'h1F30); bus_read(16'h1E00);
        bus_write(16'h1E00, 64'h1);

        // R5: per-counter enable
        cur_tag = "R5 counter enable";
        bus_write(16'h1E04, 64'h00FD);
        evt = '1; idle(3); evt = '0;
        bus_read(16'h1F08); bus_read(16'h1F00); bus_read(16'h1E04);

        // R6: upper slot bits dropped on write, zero on read
        cur_tag = "R6 slot upper bits";
        bus_write(16'h1F10, 64'hDEAD_0000_1234_5678);
        bus_read(16'h1F10);
        check(rdata[63:48] == 16'h0, "R6 upper half zero", rdata, {16'h0, rdata[47:0]});

        // R8: wrap sets status
        cur_tag = "R8 wrap status";
        bus_write(16'h1F00, 64'h0000_FFFF_FFFF_FFFE);
        evt[0] = 1'b1; idle(3); evt = '0;
        bus_read(16'h0808); bus_read(16'h1F00);
        idle(2);
        bus_read(16'h0808);

        // R10: mask polarity on the interrupt
        cur_tag = "R10 mask";
        idle(2);
        bus_write(16'h0804, 64'hFFFE);
        idle(3);
        check(irq == 1'b1, "R10 unmasked irq", {63'b0, irq}, 64'b1);
        bus_read(16'h0804);

        // R9: clear semantics and wrap-versus-clear race
        cur_tag = "R9 clear";
        bus_write(16'h080C, 64'h0);
        bus_read(16'h0808);
        bus_write(16'h080C, 64'h1);
        bus_read(16'h0808); bus_read(16'h080C);
        evt[0] = 1'b1;
        bus_write(16'h1F00, CMAX);
        bus_write(16'h080C, 64'h1);
        evt = '0;
        bus_read(16'h0808);
        bus_write(16'h080C, 64'hFFFF);
        idle(2);

        // R11: write beats a concurrent increment
        cur_tag = "R11 write priority";
        bus_write(16'h1E04, 64'h00FF);
        evt[1] = 1'b1;
        bus_write(16'h1F08, 64'd100);
        evt = '0;
        bus_read(16'h1F08);
        check(rdata == 64'd100, "R11 written value kept", rdata, 64'd100);

        // R12: unmapped and misaligned accesses
        cur_tag = "R12 unmapped";
        bus_read(16'h1234); bus_read(16'h1F04); bus_read(16'h1E90); bus_read(16'h1F80);
        bus_write(16'h1E90, '1); bus_write(16'h1F80, '1); bus_write(16'h1E02, '1);
        bus_read(16'h1E00); bus_read(16'h1E8C); bus_read(16'h1F78); bus_read(16'h1E04);
        idle(4);

        finish_run();
    end

endmodule